// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block gathers six interrupt requests for a small CPU core and resolves them into one vectored request. The six sources are two external pins, three timer overflow pulses and a serial port whose transmit and receive flags share one request. Each source has its own enable bit, and a global enable masks all of them. Each source has a priority bit that places it at the low or the high level. Among requests at the same level, a fixed polling order picks the winner.

Request state is sampled once per machine cycle, on a strobe from the core. The core also reports three events: the last cycle of an instruction, a return-from-interrupt, and an access to the enable or priority registers. A request is accepted only on a last cycle that is neither a return nor such a register access. The level in service must also leave room for it. On acceptance the block pulses a request for one cycle and presents the vector address. In the same cycle it clears the latched flag of the source, if that source has one. The block records which levels are in service, so a high-priority source can interrupt a low-priority handler. Each return releases the most recent level.

Top module: `irq_prio_ctl`

## Requirements
- R1: Out of reset, `irq_req` is 0, `flag_clr` is 0 and `irq_vector` is 0000h. No level is in service, and all enables and priorities are taken from the inputs.
- R2: A source can be accepted only while its bit in `src_en` and `global_en` are both 1. The bits are 0 ext0, 1 tmr0, 2 ext1, 3 tmr1, 4 serial, 5 tmr2.
- R3: Among eligible requests at the same priority level, the lowest bit index wins. The order is ext0, tmr0, ext1, tmr1, serial, tmr2.
- R4: An eligible source whose `src_prio` bit is 1 (high) wins over any low-priority source, whatever its index.
- R5: Acceptance happens only in a cycle with `last_cycle`=1, `reti_exec`=0 and `cfg_access`=0. In the next cycle `irq_req` is 1 for one cycle and `irq_vector` = 0003h + 8×index.
- R6: While the high level is in service, nothing is accepted. While only the low level is in service, only high-priority sources are accepted. Each `reti_exec` releases the high level if it is set, and the low level otherwise.
- R7: Pending state is latched on cycles with `mc_tick`=1. In level mode (`ext_edge` bit 0), an external request equals the inverted pin at the tick, with no latch. In edge mode (bit 1), a high-to-low pin change between ticks sets a flag that stays set until the source is accepted.
- R8: On acceptance of a timer or an edge-mode external source, `flag_clr` pulses that source's bit alongside `irq_req`, and its internal flag clears. A level-mode external or the serial source gives `flag_clr`=0.
- R9: The serial request is `ser_tx` OR `ser_rx`. It stays pending after it is accepted for as long as either input is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mc_tick | input | 1 | Machine-cycle sampling strobe |
| ext_n | input | 2 | External request pins, active low (bit0 ext0, bit1 ext1) |
| ext_edge | input | 2 | Per-pin trigger mode: 1 falling edge, 0 low level |
| timer_ovf | input | 3 | Timer overflow pulses (bit0 tmr0, bit1 tmr1, bit2 tmr2) |
| ser_tx | input | 1 | Serial transmit-done flag |
| ser_rx | input | 1 | Serial receive-done flag |
| src_en | input | 6 | Per-source enables, bit order as in R2 |
| global_en | input | 1 | Global enable |
| src_prio | input | 6 | Per-source priority, 1 high |
| last_cycle | input | 1 | Core is in the last cycle of an instruction |
| reti_exec | input | 1 | Core is executing a return-from-interrupt |
| cfg_access | input | 1 | Current instruction accesses the enable or priority setting |
| irq_req | output | 1 | One-cycle vectoring pulse |
| irq_vector | output | 16 | Vector address of the accepted source |
| flag_clr | output | 6 | One-hot clear of the taken source's latched flag |

## Verification
The hardest state to reach is nesting. A low-level handler must be in service when a high-priority source arrives while a second low-priority source is still pending. The two returns must then release the levels in the right order. The bench builds this by hand: it takes a low timer, raises a second low timer and checks that it is held, then raises a high timer and checks that it gets in. Between the two returns it checks that the held source stays blocked until the second return.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
    localparam int NSRC    = 6;
    localparam int IDX_W   = $clog2(NSRC);
    localparam int NUM_EXT = 2;
    localparam int NUM_TMR = 3;
    // polling-order positions
    localparam int SRC_EXT0 = 0;
    localparam int SRC_TMR0 = 1;
    localparam int SRC_EXT1 = 2;
    localparam int SRC_TMR1 = 3;
    localparam int SRC_SER  = 4;
    localparam int SRC_TMR2 = 5;

    typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_src_sampler.sv
module irq_src_sampler
    import irq_ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mc_tick,
    input  logic [NUM_EXT-1:0] ext_n,
    input  logic [NUM_EXT-1:0] ext_edge,
    input  logic [NUM_TMR-1:0] timer_ovf,
    input  logic               ser_tx,
    input  logic               ser_rx,
    input  src_vec_t           take,
    output src_vec_t           pend
);
    typedef struct packed {
        logic [NUM_EXT-1:0] ext_prev;
        logic [NUM_EXT-1:0] edge_flg;
        logic [NUM_TMR-1:0] tmr_flg;
        src_vec_t           pend;
    } smp_t;

    smp_t smp_d, smp_q;

    logic [NUM_EXT-1:0] take_ext;
    logic [NUM_TMR-1:0] take_tmr;
    logic [NUM_EXT-1:0] fall_now;
    logic [NUM_EXT-1:0] ext_raw;
    src_vec_t           raw;

    assign take_ext = {take[SRC_EXT1], take[SRC_EXT0]};
    assign take_tmr = {take[SRC_TMR2], take[SRC_TMR1], take[SRC_TMR0]};

    always_comb begin
        smp_d    = smp_q;
        fall_now = smp_q.ext_prev & ~ext_n & ext_edge & {NUM_EXT{mc_tick}};
        // edge flags: a new falling edge wins over a clear
        smp_d.edge_flg = (smp_q.edge_flg & ~take_ext) | fall_now;
        // timer flags: a new overflow pulse wins over a clear
        smp_d.tmr_flg  = (smp_q.tmr_flg & ~take_tmr) | timer_ovf;
        for (int k = 0; k < NUM_EXT; k++) begin
            ext_raw[k] = ext_edge[k] ? smp_d.edge_flg[k] : ~ext_n[k];
        end
        raw           = '0;
        raw[SRC_EXT0] = ext_raw[0];
        raw[SRC_EXT1] = ext_raw[1];
        raw[SRC_TMR0] = smp_d.tmr_flg[0];
        raw[SRC_TMR1] = smp_d.tmr_flg[1];
        raw[SRC_TMR2] = smp_d.tmr_flg[2];
        raw[SRC_SER]  = ser_tx | ser_rx;
        if (mc_tick) begin
            smp_d.ext_prev = ext_n;
            smp_d.pend     = raw;
        end else begin
            smp_d.pend     = smp_q.pend & ~take;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q.ext_prev <= '1;
            smp_q.edge_flg <= '0;
            smp_q.tmr_flg  <= '0;
            smp_q.pend     <= '0;
        end else begin
            smp_q <= smp_d;
        end
    end

    assign pend = smp_q.pend;
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_ctl_pkg::*;
(
    input  src_vec_t             pend,
    input  src_vec_t             en,
    input  logic                 gen,
    input  src_vec_t             prio,
    input  logic                 ins_hi,
    input  logic                 ins_lo,
    output logic                 valid,
    output logic                 hi,
    output logic [IDX_W-1:0]     idx
);
    localparam int NLVL = 2;

    src_vec_t elig;
    src_vec_t lane [NLVL];

    always_comb begin
        elig    = pend & en & {NSRC{gen}};
        lane[1] = ins_hi ? '0 : (elig & prio);
        lane[0] = (ins_hi | ins_lo) ? '0 : (elig & ~prio);
    end

    for (genvar l = 0; l < NLVL; l++) begin : g_lane
        logic             found;
        logic [IDX_W-1:0] first;
        always_comb begin
            found = 1'b0;
            first = '0;
            for (int i = NSRC - 1; i >= 0; i--) begin
                if (lane[l][i]) begin
                    found = 1'b1;
                    first = IDX_W'(i);
                end
            end
        end
    end

    assign hi    = g_lane[1].found;
    assign valid = g_lane[1].found | g_lane[0].found;
    assign idx   = g_lane[1].found ? g_lane[1].first : g_lane[0].first;
endmodule

// File: rtl/irq_prio_ctl.sv
module irq_prio_ctl
    import irq_ctl_pkg::*;
#(
    parameter int VEC_W      = 16,
    parameter int VEC_BASE   = 3,
    parameter int VEC_STRIDE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mc_tick,
    input  logic [1:0]       ext_n,
    input  logic [1:0]       ext_edge,
    input  logic [2:0]       timer_ovf,
    input  logic             ser_tx,
    input  logic             ser_rx,
    input  logic [5:0]       src_en,
    input  logic             global_en,
    input  logic [5:0]       src_prio,
    input  logic             last_cycle,
    input  logic             reti_exec,
    input  logic             cfg_access,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vector,
    output logic [5:0]       flag_clr
);
    typedef struct packed {
        logic             ins_hi;
        logic             ins_lo;
        logic             req;
        logic [VEC_W-1:0] vec;
        src_vec_t         clr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    src_vec_t         pend;
    src_vec_t         take;
    src_vec_t         clr_mask;
    logic             pick_valid;
    logic             pick_hi;
    logic [IDX_W-1:0] pick_idx;
    logic             accept;
    logic             ins_hi_w;

    irq_src_sampler u_smp (
        .clk       (clk),
        .rst_n     (rst_n),
        .mc_tick   (mc_tick),
        .ext_n     (ext_n),
        .ext_edge  (ext_edge),
        .timer_ovf (timer_ovf),
        .ser_tx    (ser_tx),
        .ser_rx    (ser_rx),
        .take      (take),
        .pend      (pend)
    );

    irq_pick u_pick (
        .pend   (pend),
        .en     (src_en),
        .gen    (global_en),
        .prio   (src_prio),
        .ins_hi (ctl_q.ins_hi),
        .ins_lo (ctl_q.ins_lo),
        .valid  (pick_valid),
        .hi     (pick_hi),
        .idx    (pick_idx)
    );

    always_comb begin
        clr_mask           = '0;
        clr_mask[SRC_TMR0] = 1'b1;
        clr_mask[SRC_TMR1] = 1'b1;
        clr_mask[SRC_TMR2] = 1'b1;
        clr_mask[SRC_EXT0] = ext_edge[0];
        clr_mask[SRC_EXT1] = ext_edge[1];

        accept = last_cycle & ~reti_exec & ~cfg_access & pick_valid;
        take   = accept ? (src_vec_t'(1) << pick_idx) : '0;

        ctl_d     = ctl_q;
        ctl_d.req = accept;
        ctl_d.clr = take & clr_mask;
        if (accept) begin
            ctl_d.vec = VEC_W'(VEC_BASE) + VEC_W'(VEC_STRIDE) * VEC_W'(pick_idx);
            if (pick_hi) ctl_d.ins_hi = 1'b1;
            else         ctl_d.ins_lo = 1'b1;
        end else if (reti_exec) begin
            if (ctl_q.ins_hi) ctl_d.ins_hi = 1'b0;
            else              ctl_d.ins_lo = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign irq_req    = ctl_q.req;
    assign irq_vector = ctl_q.vec;
    assign flag_clr   = ctl_q.clr;
    assign ins_hi_w   = ctl_q.ins_hi;
endmodule

// File: rtl/irq_prio_ctl_chk.sv
module irq_prio_ctl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        last_cycle,
    input logic        reti_exec,
    input logic        cfg_access,
    input logic        irq_req,
    input logic [15:0] irq_vector,
    input logic [5:0]  flag_clr,
    input logic        ins_hi
);
    // R5: a vectoring pulse follows a permitted acceptance slot
    assert_req_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(last_cycle && !reti_exec && !cfg_access));

    // R5: vector lies on the 8-byte grid starting at 0003h
    assert_vec_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vector[2:0] == 3'd3 && irq_vector <= 16'h002B));

    // R6: with the high level in service nothing is taken next
    assert_ins_hi_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ins_hi |=> !irq_req);

    // R8: at most one flag cleared, and only with a vectoring pulse
    assert_clr_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flag_clr) && (flag_clr == 6'd0 || irq_req));

    // R8: the serial vector never clears a flag
    assert_ser_noclr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_vector == 16'h0023) |-> flag_clr == 6'd0);
endmodule

bind irq_prio_ctl irq_prio_ctl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .last_cycle (last_cycle),
    .reti_exec  (reti_exec),
    .cfg_access (cfg_access),
    .irq_req    (irq_req),
    .irq_vector (irq_vector),
    .flag_clr   (flag_clr),
    .ins_hi     (ins_hi_w)
);

// File: tb/irq_prio_ctl_tb.sv
module irq_prio_ctl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mc_tick = 1'b0;
    logic [1:0]  ext_n = 2'b11;
    logic [1:0]  ext_edge = 2'b11;
    logic [2:0]  timer_ovf = 3'b000;
    logic        ser_tx = 1'b0;
    logic        ser_rx = 1'b0;
    logic [5:0]  src_en = 6'h3F;
    logic        global_en = 1'b1;
    logic [5:0]  src_prio = 6'h00;
    logic        last_cycle = 1'b0;
    logic        reti_exec = 1'b0;
    logic        cfg_access = 1'b0;
    logic        irq_req;
    logic [15:0] irq_vector;
    logic [5:0]  flag_clr;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    irq_prio_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .ext_n(ext_n),
        .ext_edge(ext_edge), .timer_ovf(timer_ovf), .ser_tx(ser_tx),
        .ser_rx(ser_rx), .src_en(src_en), .global_en(global_en),
        .src_prio(src_prio), .last_cycle(last_cycle), .reti_exec(reti_exec),
        .cfg_access(cfg_access), .irq_req(irq_req), .irq_vector(irq_vector),
        .flag_clr(flag_clr)
    );

    typedef struct packed {
        logic [5:0] en;
        logic [5:0] prio;
        logic       gen;
        logic [1:0] extn;
        logic [1:0] mode;
        logic [2:0] tmr;
        logic [1:0] ser;   // {tx, rx}
        logic       req;
        logic [2:0] idx;
        logic [5:0] clr;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t TBL [NVEC] = '{
        '{6'h3F, 6'h00, 1'b1, 2'b10, 2'b00, 3'b000, 2'b00, 1'b1, 3'd0, 6'h00},
        '{6'h3F, 6'h00, 1'b1, 2'b10, 2'b01, 3'b000, 2'b00, 1'b1, 3'd0, 6'h01},
        '{6'h3F, 6'h00, 1'b1, 2'b11, 2'b11, 3'b001, 2'b00, 1'b1, 3'd1, 6'h02},
        '{6'h3F, 6'h00, 1'b1, 2'b11, 2'b11, 3'b110, 2'b00, 1'b1, 3'd3, 6'h08},
        '{6'h3F, 6'h20, 1'b1, 2'b11, 2'b11, 3'b101, 2'b00, 1'b1, 3'd5, 6'h20},
        '{6'h3F, 6'h00, 1'b1, 2'b11, 2'b11, 3'b000, 2'b01, 1'b1, 3'd4, 6'h00},
        '{6'h2F, 6'h00, 1'b1, 2'b11, 2'b11, 3'b000, 2'b10, 1'b0, 3'd0, 6'h00},
        '{6'h3F, 6'h00, 1'b0, 2'b11, 2'b11, 3'b001, 2'b00, 1'b0, 3'd0, 6'h00},
        '{6'h3F, 6'h00, 1'b1, 2'b01, 2'b10, 3'b000, 2'b00, 1'b1, 3'd2, 6'h04},
        '{6'h3F, 6'h04, 1'b1, 2'b00, 2'b00, 3'b111, 2'b11, 1'b1, 3'd2, 6'h00},
        '{6'h3E, 6'h00, 1'b1, 2'b10, 2'b00, 3'b000, 2'b00, 1'b0, 3'd0, 6'h00}
    };

    function automatic string vec_tag(int v);
        case (v)
            0:  return "R7 level ext0";
            1:  return "R8 edge ext0";
            2:  return "R8 tmr0";
            3:  return "R3 tmr1 over tmr2";
            4:  return "R4 high tmr2";
            5:  return "R9 serial rx";
            6:  return "R2 serial disabled";
            7:  return "R2 global off";
            8:  return "R8 edge ext1";
            9:  return "R4 high ext1 among all";
            default: return "R2 ext0 disabled";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk) mc_tick = 1'b1;
        @(negedge clk) mc_tick = 1'b0;
    endtask

    task automatic lc(logic r, logic c);
        @(negedge clk) begin last_cycle = 1'b1; reti_exec = r; cfg_access = c; end
        @(negedge clk) begin last_cycle = 1'b0; reti_exec = 1'b0; cfg_access = 1'b0; end
    endtask

    task automatic reti_p();
        @(negedge clk) reti_exec = 1'b1;
        @(negedge clk) reti_exec = 1'b0;
    endtask

    task automatic pulse_tmr(logic [2:0] t);
        @(negedge clk) timer_ovf = t;
        @(negedge clk) timer_ovf = 3'b000;
    endtask

    task automatic expect_take(string tag, int idx, logic [5:0] clr);
        check({tag, " req"}, 32'(irq_req), 32'd1);
        check({tag, " vector"}, 32'(irq_vector), 32'(3 + 8 * idx));
        check({tag, " clr"}, 32'(flag_clr), 32'(clr));
    endtask

    task automatic expect_none(string tag);
        check({tag, " no req"}, 32'(irq_req), 32'd0);
        check({tag, " no clr"}, 32'(flag_clr), 32'd0);
    endtask

    task automatic drain();
        @(negedge clk) begin
            ext_n = 2'b11; ext_edge = 2'b11; ser_tx = 1'b0; ser_rx = 1'b0;
            src_en = 6'h3F; src_prio = 6'h00; global_en = 1'b1;
        end
        for (int k = 0; k < 8; k++) begin
            tick();
            lc(1'b0, 1'b0);
            if (irq_req) reti_p();
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: act=%0d exp=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: values during and right after reset
        check("R1 req in reset", 32'(irq_req), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 req", 32'(irq_req), 32'd0);
        check("R1 clr", 32'(flag_clr), 32'd0);
        check("R1 vector", 32'(irq_vector), 32'd0);
        lc(1'b0, 1'b0);
        expect_none("R1 nothing pending");

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk) begin
                src_en = TBL[v].en; src_prio = TBL[v].prio; global_en = TBL[v].gen;
                ext_edge = TBL[v].mode; ext_n = TBL[v].extn;
                ser_tx = TBL[v].ser[1]; ser_rx = TBL[v].ser[0];
                timer_ovf = TBL[v].tmr;
            end
            @(negedge clk) begin timer_ovf = 3'b000; mc_tick = 1'b1; end
            @(negedge clk) begin mc_tick = 1'b0; last_cycle = 1'b1; end
            @(negedge clk) last_cycle = 1'b0;
            if (TBL[v].req) expect_take(vec_tag(v), int'(TBL[v].idx), TBL[v].clr);
            else            expect_none(vec_tag(v));
            if (irq_req) reti_p();
            drain();
        end

        // R6: nesting of levels
        pulse_tmr(3'b001); tick(); lc(1'b0, 1'b0);
        expect_take("R6 low tmr0 taken", 1, 6'h02);
        pulse_tmr(3'b010); tick(); lc(1'b0, 1'b0);
        expect_none("R6 low blocked by low");
        @(negedge clk) src_prio = 6'h20;
        pulse_tmr(3'b100); tick(); lc(1'b0, 1'b0);
        expect_take("R6 high nests over low", 5, 6'h20);
        lc(1'b0, 1'b0);
        expect_none("R6 high in service blocks");
        reti_p(); lc(1'b0, 1'b0);
        expect_none("R6 low still in service");
        reti_p(); lc(1'b0, 1'b0);
        expect_take("R6 held low taken after returns", 3, 6'h08);
        reti_p(); drain();

        // R5: acceptance hold-offs
        pulse_tmr(3'b001); tick();
        lc(1'b1, 1'b0); expect_none("R5 held by reti");
        lc(1'b0, 1'b1); expect_none("R5 held by cfg access");
        tick();         expect_none("R5 no last cycle");
        lc(1'b0, 1'b0); expect_take("R5 taken after hold-offs", 1, 6'h02);
        @(negedge clk);
        check("R5 pulse one cycle", 32'(irq_req), 32'd0);
        reti_p(); drain();

        // R9: serial flag stays pending
        @(negedge clk) ser_tx = 1'b1;
        tick(); lc(1'b0, 1'b0);
        expect_take("R9 serial tx", 4, 6'h00);
        reti_p(); tick(); lc(1'b0, 1'b0);
        expect_take("R9 serial still pending", 4, 6'h00);
        reti_p(); drain();

        // R7: level mode has no latch, edge mode latches
        @(negedge clk) begin ext_edge = 2'b00; ext_n = 2'b10; end
        tick();
        @(negedge clk) ext_n = 2'b11;
        tick(); lc(1'b0, 1'b0);
        expect_none("R7 level released before poll");
        @(negedge clk) begin ext_edge = 2'b01; ext_n = 2'b10; end
        tick();
        @(negedge clk) ext_n = 2'b11;
        tick(); lc(1'b0, 1'b0);
        expect_take("R7 edge latched", 0, 6'h01);
        reti_p(); tick(); lc(1'b0, 1'b0);
        expect_none("R8 edge flag cleared");
        drain();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule